// File: doc/BRIEF.md
# Symmetric Up-Down PWM Time Base with Phase Synchronisation

The block is a width-parameterised counter that climbs from zero to a period value and then descends back to zero. The result is a symmetric triangle carrier whose full cycle lasts twice the period value. It drives out the current count and the direction of travel. It also gives one-cycle strobes when the count sits at zero and when it sits at the period value. A comparator stage elsewhere uses these to update compare registers at fixed points in each switching cycle.

The period can be written in two ways. In immediate mode it takes effect on the next clock. In shadowed mode the write is buffered, and the working period is refreshed only when the count is zero. Software can also write the count directly to set a start value.

Several time bases can be chained. When phase following is enabled, a synchronisation input forces the count to a programmed phase value and sets the direction to a programmed one. A selectable synchronisation output either repeats the input combinationally, for daisy-chaining, or marks the zero point of this counter, for a master.

Top module: `updown_timebase`

## Requirements
- R1: After reset the count is 0, `dir_up` is 1, the working period is 0, `zero_stb` is 1, and the count holds at 0 while the working period is 0.
- R2: With a working period P greater than 0 and no sync or count write, the count steps by one per clock through 0, 1, …, P, P-1, …, 1, 0, 1, … Each of the turnaround values 0 and P is held for exactly one clock, so one carrier cycle lasts 2P clocks.
- R3: `dir_up` is 1 on every clock whose count was reached by a rising step, including P. It is 0 on every clock reached by a falling step, including 0.
- R4: `zero_stb` is 1 exactly on clocks where the count equals 0. `prd_stb` is 1 exactly on clocks where the count equals the working period.
- R5: With `prd_shadow_en` = 0, a `prd_wr` pulse makes `prd_wdata` the working period from the next clock on.
- R6: With `prd_shadow_en` = 1, a `prd_wr` pulse stores `prd_wdata` in a buffer only. The working period takes the buffered value at the clock edge that ends a cycle whose count is 0.
- R7: A `cnt_wr` pulse loads `cnt_wdata` into the count on the next clock and leaves `dir_up` unchanged. It overrides the turnaround at 0 or P.
- R8: When `phase_en` = 1, a `sync_in` pulse loads `phase_val` into the count and `phase_dir_up` into `dir_up` on the next clock. It takes priority over both `cnt_wr` and any turnaround in the same clock.
- R9: When `phase_en` = 0, `sync_in` has no effect on the count or the direction.
- R10: With `sync_out_sel` = 0, `sync_out` equals `sync_in` in the same clock. With `sync_out_sel` = 1, `sync_out` is 1 exactly on clocks where the count equals 0, regardless of `sync_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prd_shadow_en | input | 1 | 1 = period writes go to the buffer and reload at zero |
| prd_wr | input | 1 | Period write strobe |
| prd_wdata | input | CNT_W | Period write value |
| cnt_wr | input | 1 | Direct count write strobe |
| cnt_wdata | input | CNT_W | Direct count write value |
| phase_en | input | 1 | 1 = follow `sync_in` (slave) |
| phase_val | input | CNT_W | Count value loaded on sync |
| phase_dir_up | input | 1 | Direction after a sync load (1 = up) |
| sync_in | input | 1 | Synchronisation input |
| sync_out_sel | input | 1 | 0 = pass `sync_in`, 1 = pulse at count zero |
| cnt_out | output | CNT_W | Current count |
| dir_up | output | 1 | Current direction (1 = rising) |
| zero_stb | output | 1 | Count equals zero |
| prd_stb | output | 1 | Count equals working period |
| sync_out | output | 1 | Synchronisation output |

## Verification
The collision that matters is a sync phase load landing on the same clock as a turnaround at zero, with a direct count write also asserted. The bench times a `sync_in` pulse for the one clock where the count rests at 0 while descending. In that same clock it drives `cnt_wr` with a different value. The phase value and programmed direction must appear on the next clock, and the write value must not. A second collision places a buffered period write mid-cycle. The old period must persist through one more peak, and the new one must apply only after the next zero.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } tb_dir_e;

  typedef enum logic {
    SO_PASS = 1'b0,
    SO_ZERO = 1'b1
  } so_sel_e;

endpackage

// File: rtl/tbase_period.sv
module tbase_period #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRD_INIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shadow_en,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             at_zero,
  output logic [CNT_W-1:0] active_prd
);

  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(PRD_INIT);

  logic [CNT_W-1:0] shadow_q, shadow_d;
  logic [CNT_W-1:0] active_q, active_d;
  logic             shadow_ce, active_ce;

  always_comb begin
    shadow_d  = shadow_q;
    active_d  = active_q;
    shadow_ce = 1'b0;
    active_ce = 1'b0;
    if (wr) begin
      shadow_d  = wdata;
      shadow_ce = 1'b1;
    end
    if (!shadow_en && wr) begin
      active_d  = wdata;
      active_ce = 1'b1;
    end else if (shadow_en && at_zero) begin
      active_d  = shadow_q;
      active_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RST_VAL;
    end else if (shadow_ce) begin
      shadow_q <= shadow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= RST_VAL;
    end else if (active_ce) begin
      active_q <= active_d;
    end
  end

  assign active_prd = active_q;

  AST_IMM_PRD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!shadow_en && wr) |=> (active_q == $past(wdata))); // R5

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_en && !at_zero) |=> $stable(active_q)); // R6

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbase_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] active_prd,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             sync_load,
  input  logic [CNT_W-1:0] phase_val,
  input  logic             phase_dir_up,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  tb_dir_e          dir_q, dir_d;
  logic             cnt_ce;
  logic             run;

  assign run = (active_prd != ZERO);

  always_comb begin
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    cnt_ce = 1'b1;
    if (sync_load) begin
      cnt_d = phase_val;
      dir_d = phase_dir_up ? DIR_UP : DIR_DOWN;
    end else if (cnt_wr) begin
      cnt_d = cnt_wdata;
    end else if (!run) begin
      cnt_d  = ZERO;
      cnt_ce = (cnt_q != ZERO);
    end else if (dir_q == DIR_UP) begin
      if (cnt_q >= active_prd) begin
        cnt_d = cnt_q - ONE;
        dir_d = DIR_DOWN;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      if (cnt_q == ZERO) begin
        cnt_d = ONE;
        dir_d = DIR_UP;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      dir_q <= DIR_UP;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt    = cnt_q;
  assign dir_up = (dir_q == DIR_UP);

  AST_TURN_AT_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_load && !cnt_wr && dir_q == DIR_UP && run && cnt_q == active_prd)
    |=> (cnt_q == $past(cnt_q) - ONE && dir_q == DIR_DOWN)); // R2

  AST_TURN_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_load && !cnt_wr && dir_q == DIR_DOWN && run && cnt_q == ZERO)
    |=> (cnt_q == ONE && dir_q == DIR_UP)); // R3

  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !sync_load)
    |=> (cnt_q == $past(cnt_wdata) && dir_q == $past(dir_q))); // R7

  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sync_load
    |=> (cnt_q == $past(phase_val) && dir_up == $past(phase_dir_up))); // R8

endmodule

// File: rtl/tbase_events.sv
module tbase_events
  import tbase_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] active_prd,
  input  logic             sync_in,
  input  logic             sync_out_sel,
  output logic             zero_stb,
  output logic             prd_stb,
  output logic             sync_out
);

  so_sel_e sel;

  assign sel      = so_sel_e'(sync_out_sel);
  assign zero_stb = (cnt == '0);
  assign prd_stb  = (cnt == active_prd);

  always_comb begin
    unique case (sel)
      SO_PASS: sync_out = sync_in;
      SO_ZERO: sync_out = zero_stb;
      default: sync_out = 1'b0;
    endcase
  end

  AST_ZERO_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SO_ZERO && sync_out && active_prd != '0 && $stable(active_prd))
    |=> !sync_out); // R10

endmodule

// File: rtl/updown_timebase.sv
module updown_timebase #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRD_INIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prd_shadow_en,
  input  logic             prd_wr,
  input  logic [CNT_W-1:0] prd_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             phase_en,
  input  logic [CNT_W-1:0] phase_val,
  input  logic             phase_dir_up,
  input  logic             sync_in,
  input  logic             sync_out_sel,
  output logic [CNT_W-1:0] cnt_out,
  output logic             dir_up,
  output logic             zero_stb,
  output logic             prd_stb,
  output logic             sync_out
);

  logic [CNT_W-1:0] active_prd;
  logic [CNT_W-1:0] cnt;
  logic             sync_load;
  logic             at_zero;

  assign sync_load = sync_in && phase_en;

  tbase_period #(
    .CNT_W   (CNT_W),
    .PRD_INIT(PRD_INIT)
  ) u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .shadow_en (prd_shadow_en),
    .wr        (prd_wr),
    .wdata     (prd_wdata),
    .at_zero   (at_zero),
    .active_prd(active_prd)
  );

  tbase_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_prd  (active_prd),
    .cnt_wr      (cnt_wr),
    .cnt_wdata   (cnt_wdata),
    .sync_load   (sync_load),
    .phase_val   (phase_val),
    .phase_dir_up(phase_dir_up),
    .cnt         (cnt),
    .dir_up      (dir_up)
  );

  tbase_events #(
    .CNT_W(CNT_W)
  ) u_events (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt         (cnt),
    .active_prd  (active_prd),
    .sync_in     (sync_in),
    .sync_out_sel(sync_out_sel),
    .zero_stb    (at_zero),
    .prd_stb     (prd_stb),
    .sync_out    (sync_out)
  );

  assign zero_stb = at_zero;
  assign cnt_out  = cnt;

  AST_SYNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && !phase_en && !cnt_wr && active_prd != '0 && cnt != '0 && cnt < active_prd)
    |=> (cnt != $past(cnt) && (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1))); // R9

endmodule

// File: tb/sim_updown_timebase.sv
module sim_updown_timebase;

  localparam int W = 16;

  typedef struct {
    int    cyc;
    int    kind;
    int    val;
    string req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         prd_shadow_en, prd_wr, cnt_wr, phase_en, phase_dir_up;
  logic         sync_in, sync_out_sel;
  logic [W-1:0] prd_wdata, cnt_wdata, phase_val;
  logic [W-1:0] cnt_out;
  logic         dir_up, zero_stb, prd_stb, sync_out;

  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   done = 0;
  int   k;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  updown_timebase #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .prd_shadow_en(prd_shadow_en), .prd_wr(prd_wr),
    .prd_wdata(prd_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .phase_en(phase_en), .phase_val(phase_val), .phase_dir_up(phase_dir_up),
    .sync_in(sync_in), .sync_out_sel(sync_out_sel), .cnt_out(cnt_out),
    .dir_up(dir_up), .zero_stb(zero_stb), .prd_stb(prd_stb), .sync_out(sync_out)
  );

  // kind: 0 count, 1 direction, 2 zero strobe, 3 period strobe, 4 sync out
  function automatic int actual(int kind);
    case (kind)
      0: return int'(cnt_out);
      1: return int'(dir_up);
      2: return int'(zero_stb);
      3: return int'(prd_stb);
      default: return int'(sync_out);
    endcase
  endfunction

  task automatic expect_at(int c, int kind, int val, string req);
    exp_t e;
    e.cyc = c; e.kind = kind; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic expect_cd(int c, int cv, int dv, string req);
    expect_at(c, 0, cv, req);
    expect_at(c, 1, dv, req);
  endtask

  task automatic go_to(int c);
    while (cyc < c) begin
      @(posedge clk);
      #2;
    end
  endtask

  // monitor: scoreboard pop and compare, away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_tests++;
      if (e.cyc < cyc) begin
        n_fail++;
        $display("FAIL %s kind %0d missed at cycle %0d: actual none expected %0d", e.req, e.kind, e.cyc, e.val);
      end else if (actual(e.kind) != e.val) begin
        n_fail++;
        $display("FAIL %s kind %0d cycle %0d: actual %0d expected %0d", e.req, e.kind, cyc, actual(e.kind), e.val);
      end
    end
  end

  initial begin
    rst_n = 1'b0; prd_shadow_en = 1'b0; prd_wr = 1'b0; cnt_wr = 1'b0;
    phase_en = 1'b0; phase_dir_up = 1'b0; sync_in = 1'b0; sync_out_sel = 1'b0;
    prd_wdata = '0; cnt_wdata = '0; phase_val = '0;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    k = cyc;

    // R1 reset state
    expect_cd(k, 0, 1, "R1");
    expect_at(k, 2, 1, "R1");
    expect_at(k, 4, 0, "R1");
    // R5 immediate period write, R2/R3/R4 triangle
    expect_cd(k+1, 0, 1, "R1");
    expect_cd(k+2, 1, 1, "R5");
    expect_cd(k+3, 2, 1, "R2");
    expect_cd(k+5, 4, 1, "R3");
    expect_at(k+5, 3, 1, "R4");
    expect_at(k+5, 2, 0, "R4");
    expect_cd(k+6, 3, 0, "R3");
    expect_at(k+6, 3, 0, "R4");
    expect_cd(k+8, 1, 0, "R2");
    expect_cd(k+9, 0, 0, "R3");
    expect_at(k+9, 2, 1, "R4");
    expect_cd(k+10, 1, 1, "R2");
    // R6 buffered period
    expect_cd(k+13, 4, 1, "R6");
    expect_at(k+13, 3, 1, "R6");
    expect_cd(k+17, 0, 0, "R2");
    expect_cd(k+18, 1, 1, "R6");
    expect_cd(k+19, 2, 1, "R6");
    expect_at(k+19, 3, 1, "R6");
    expect_cd(k+20, 1, 0, "R6");
    // R7 count write at peak
    expect_cd(k+24, 0, 1, "R7");
    expect_cd(k+25, 1, 1, "R7");
    // R9 and R10 pass-through
    expect_at(k+26, 4, 1, "R10");
    expect_cd(k+27, 1, 0, "R9");
    // R8 sync vs turnaround and count write
    expect_cd(k+29, 1, 0, "R8");
    expect_cd(k+30, 0, 0, "R8");
    expect_cd(k+31, 1, 1, "R8");
    // R10 zero-pulse select
    expect_at(k+31, 4, 0, "R10");
    expect_at(k+32, 4, 0, "R10");
    expect_at(k+33, 4, 0, "R10");
    expect_cd(k+34, 0, 0, "R9");
    expect_at(k+34, 4, 1, "R10");
    // R8 sync with upward direction
    expect_cd(k+36, 2, 1, "R8");
    expect_at(k+36, 3, 1, "R8");
    expect_cd(k+37, 1, 0, "R8");

    go_to(k);
    prd_wr = 1'b1; prd_wdata = 16'd4;
    go_to(k+1);
    prd_wr = 1'b0;

    go_to(k+10);
    prd_shadow_en = 1'b1; prd_wr = 1'b1; prd_wdata = 16'd2;
    go_to(k+11);
    prd_wr = 1'b0;

    go_to(k+23);
    cnt_wr = 1'b1; cnt_wdata = 16'd0;
    go_to(k+24);
    cnt_wr = 1'b0;

    go_to(k+26);
    sync_in = 1'b1; phase_en = 1'b0; phase_val = 16'd0; phase_dir_up = 1'b1;
    go_to(k+27);
    sync_in = 1'b0;

    go_to(k+28);
    sync_in = 1'b1; phase_en = 1'b1; phase_val = 16'd1; phase_dir_up = 1'b0;
    cnt_wr = 1'b1; cnt_wdata = 16'd2;
    go_to(k+29);
    sync_in = 1'b0; cnt_wr = 1'b0; phase_en = 1'b0;

    go_to(k+31);
    sync_out_sel = 1'b1;
    go_to(k+33);
    sync_in = 1'b1;
    go_to(k+34);
    sync_in = 1'b0;

    go_to(k+35);
    sync_in = 1'b1; phase_en = 1'b1; phase_val = 16'd2; phase_dir_up = 1'b1;
    go_to(k+36);
    sync_in = 1'b0; phase_en = 1'b0;

    go_to(k+40);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d items left expected 0", q.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule